// File: doc/BRIEF.md
# Arithmetic Three-Weight Test Vector Generator

This block produces weighted pseudo-random test vectors for a built-in self-test path. It reuses one accumulator and its ripple-carry adder, so no separate weighting gates are needed. Each bit of the vector takes one of three weights: always 1, always 0, or an even chance of either. Two per-bit mask vectors select the weight. They set the two adder operands of that bit, and a forced bit lets the carry pass straight through. The bits that are not forced receive the sum of the accumulator and an external random word.

Vectors leave the block over a valid/ready stream. The accumulator advances once per accepted transfer. When `vec_valid` is high and `vec_ready` is low, the vector and `vec_valid` hold. When `enable` is low, no new vector is made, and `vec_valid` drops once the pending vector has been taken. If a bit is marked both "force 1" and "force 0", the block treats it as a random bit and raises a sticky error flag.

Top module: `tpg_arith3w`

## Requirements
- R1: After reset, `vec_data` is all zeros and `vec_valid` and `pair_err` are both low.
- R2: A bit with `set_mask`=1 and `clr_mask`=0 reads 1 in every vector produced with that mask.
- R3: A bit with `set_mask`=0 and `clr_mask`=1 reads 0 in every vector produced with that mask.
- R4: A bit with both masks at 0 takes the sum bit of `vec_data[i]` + `rnd_in[i]` + carry[i]. Carry into bit 0 is 0, and the carry out of the top bit is dropped.
- R5: A forced bit (R2 or R3) passes its carry-in unchanged to the next bit.
- R6: A bit with both masks at 1 behaves as in R4. `pair_err` rises after any advance that used such a mask and stays high until reset.
- R7: The generator advances when `enable`=1 and (`vec_valid`=0 or `vec_ready`=1). `vec_valid` is high in the following cycle.
- R8: While `vec_valid`=1 and `vec_ready`=0, `vec_data` and `vec_valid` stay unchanged.
- R9: With `enable`=0 and `vec_ready`=1, `vec_valid` falls after the next edge and `vec_data` is unchanged.
- R10: Over 1000 vectors with fixed masks and an unbiased `rnd_in`, forced bits never change, and each random bit is 1 in 40% to 60% of the vectors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Permits new vectors to be generated |
| set_mask | input | WIDTH | Per-bit force-to-1 selector |
| clr_mask | input | WIDTH | Per-bit force-to-0 selector |
| rnd_in | input | WIDTH | Random addend for the unforced bits |
| vec_data | output | WIDTH | Current test vector |
| vec_valid | output | 1 | Vector is valid |
| vec_ready | input | 1 | Consumer accepts the vector |
| pair_err | output | 1 | Sticky flag for a bit with both masks set |

## Verification
Weight forcing and carry propagation act in the same advance whenever a forced bit sits between random bits. The table row that clears bit 3 while bits 0 to 2 overflow provokes this case. It is judged by the carry arriving at bit 4 while bit 3 still reads 0. The illegal mask pair and a normal carry chain also meet in one advance. That row is judged by the expected sum together with `pair_err` rising.

// File: rtl/tpg_pkg.sv
package tpg_pkg;
  typedef enum logic [1:0] {
    WT_RAND = 2'b00,
    WT_ZERO = 2'b01,
    WT_ONE  = 2'b10,
    WT_BAD  = 2'b11
  } weight_e;

  function automatic weight_e decode_weight(input logic s, input logic c);
    return weight_e'({s, c});
  endfunction
endpackage

// File: rtl/tpg_weight_cell.sv
module tpg_weight_cell
  import tpg_pkg::*;
(
  input  logic s_bit,
  input  logic c_bit,
  input  logic acc_bit,
  input  logic rnd_bit,
  output logic op_a,
  output logic op_b,
  output logic frc_en,
  output logic frc_val,
  output logic bad
);
  weight_e w;
  always_comb begin
    w       = decode_weight(s_bit, c_bit);
    op_a    = acc_bit;
    op_b    = rnd_bit;
    frc_en  = 1'b0;
    frc_val = 1'b0;
    bad     = 1'b0;
    unique case (w)
      WT_ONE:  begin op_a = 1'b1; op_b = 1'b0; frc_en = 1'b1; frc_val = 1'b1; end
      WT_ZERO: begin op_a = 1'b0; op_b = 1'b1; frc_en = 1'b1; frc_val = 1'b0; end
      WT_BAD:  bad = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/tpg_full_adder.sv
module tpg_full_adder (
  input  logic a,
  input  logic b,
  input  logic ci,
  output logic s,
  output logic co
);
  assign s  = a ^ b ^ ci;
  assign co = (a & b) | (ci & (a ^ b));
endmodule

// File: rtl/tpg_ripple_adder.sv
module tpg_ripple_adder #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] s
);
  logic [WIDTH-1:0] c;
  assign c[0] = 1'b0;
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    if (i < WIDTH - 1) begin : g_fa
      tpg_full_adder fa_i (.a(a[i]), .b(b[i]), .ci(c[i]), .s(s[i]), .co(c[i+1]));
    end else begin : g_top
      assign s[i] = a[i] ^ b[i] ^ c[i];
    end
  end
endmodule

// File: rtl/tpg_arith3w.sv
module tpg_arith3w #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [WIDTH-1:0] set_mask,
  input  logic [WIDTH-1:0] clr_mask,
  input  logic [WIDTH-1:0] rnd_in,
  output logic [WIDTH-1:0] vec_data,
  output logic             vec_valid,
  input  logic             vec_ready,
  output logic             pair_err
);
  logic [WIDTH-1:0] acc_q, op_a, op_b, frc_en, frc_val, bad, sum, nxt;
  logic             adv, err_q, vld_q;

  for (genvar i = 0; i < WIDTH; i++) begin : g_cell
    tpg_weight_cell cell_i (
      .s_bit(set_mask[i]), .c_bit(clr_mask[i]), .acc_bit(acc_q[i]), .rnd_bit(rnd_in[i]),
      .op_a(op_a[i]), .op_b(op_b[i]), .frc_en(frc_en[i]), .frc_val(frc_val[i]), .bad(bad[i])
    );
    assign nxt[i] = frc_en[i] ? frc_val[i] : sum[i];
  end

  tpg_ripple_adder #(.WIDTH(WIDTH)) add_i (.a(op_a), .b(op_b), .s(sum));

  assign adv = enable && (!vld_q || vec_ready);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= '0;
      vld_q <= 1'b0;
      err_q <= 1'b0;
    end else if (adv) begin
      acc_q <= nxt;
      vld_q <= 1'b1;
      if (|bad) err_q <= 1'b1;
    end else if (!enable && vec_ready) begin
      vld_q <= 1'b0;
    end
  end

  assign vec_data  = acc_q;
  assign vec_valid = vld_q;
  assign pair_err  = err_q;
endmodule

// File: rtl/tpg_arith3w_chk.sv
module tpg_arith3w_chk #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic [WIDTH-1:0] set_mask,
  input logic [WIDTH-1:0] clr_mask,
  input logic [WIDTH-1:0] vec_data,
  input logic             vec_valid,
  input logic             vec_ready,
  input logic             pair_err
);
  logic go;
  assign go = enable && (!vec_valid || vec_ready);

  p_force_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> ((vec_data & $past(set_mask & ~clr_mask)) == $past(set_mask & ~clr_mask)));
  p_force_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> ((vec_data & $past(clr_mask & ~set_mask)) == '0));
  p_err_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (go && |(set_mask & clr_mask)) |=> pair_err);
  p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pair_err |=> pair_err);
  p_valid_after_go_r7: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> vec_valid);
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && !vec_ready) |=> (vec_valid && $stable(vec_data)));
  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !go |=> $stable(vec_data));
endmodule

bind tpg_arith3w tpg_arith3w_chk #(.WIDTH(WIDTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .enable(enable), .set_mask(set_mask), .clr_mask(clr_mask),
  .vec_data(vec_data), .vec_valid(vec_valid), .vec_ready(vec_ready), .pair_err(pair_err)
);

// File: tb/tpg_arith3w_tb.sv
`timescale 1ns/1ps
module tpg_arith3w_tb_top;
  localparam int W = 8;
  localparam int NROWS = 9;
  // {set_mask, clr_mask, rnd_in, expected vec_data}, applied from reset in order
  localparam logic [31:0] TBL [NROWS] = '{
    32'h00_00_35_35, 32'h00_00_0F_44, 32'h80_01_11_D4, 32'h0F_F0_AA_0F,
    32'h00_00_F1_00, 32'h00_08_07_07, 32'h00_08_01_10, 32'h08_00_0F_1F,
    32'h01_01_01_20
  };
  localparam string TAG [NROWS] = '{"R4", "R4", "R2 R3 R4", "R2 R3", "R4",
                                     "R3", "R5", "R2 R5", "R6"};

  logic clk = 1'b0, rst_n = 1'b0, enable = 1'b0, vec_ready = 1'b0;
  logic [W-1:0] set_mask = '0, clr_mask = '0, rnd_in = '0;
  logic [W-1:0] vec_data;
  logic vec_valid, pair_err;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  tpg_arith3w #(.WIDTH(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .set_mask(set_mask), .clr_mask(clr_mask),
    .rnd_in(rnd_in), .vec_data(vec_data), .vec_valid(vec_valid), .vec_ready(vec_ready),
    .pair_err(pair_err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] xs;
    int ones [W];
    int frc_bad;
    repeat (3) step();
    chk("R1 data", vec_data, 0);
    chk("R1 valid", vec_valid, 0);
    chk("R1 err", pair_err, 0);
    rst_n = 1'b1;
    step();

    // table walk: every row is one accepted advance
    enable = 1'b1; vec_ready = 1'b1;
    for (int r = 0; r < NROWS; r++) begin
      {set_mask, clr_mask, rnd_in} = TBL[r][31:8];
      step();
      chk({TAG[r], " vector"}, vec_data, TBL[r][7:0]);
      chk("R7 valid", vec_valid, 1);
      chk("R6 err", pair_err, (r == NROWS - 1));
    end

    // back-pressure hold
    set_mask = '0; clr_mask = '0; rnd_in = 8'h01; vec_ready = 1'b0;
    repeat (3) step();
    chk("R8 data held", vec_data, 8'h20);
    chk("R8 valid held", vec_valid, 1);
    chk("R6 err sticky", pair_err, 1);

    // idle with enable low
    enable = 1'b0; vec_ready = 1'b1;
    step();
    chk("R9 valid drop", vec_valid, 0);
    chk("R9 data kept", vec_data, 8'h20);
    step();
    chk("R9 data still", vec_data, 8'h20);

    // advance from empty even without ready
    enable = 1'b1; vec_ready = 1'b0;
    step();
    chk("R7 advance empty", vec_data, 8'h21);
    chk("R7 valid", vec_valid, 1);
    step();
    chk("R8 hold again", vec_data, 8'h21);

    // reset clears sticky error
    rst_n = 1'b0; enable = 1'b0;
    step();
    chk("R1 err cleared", pair_err, 0);
    chk("R1 data cleared", vec_data, 0);
    rst_n = 1'b1;

    // statistics: bits 1:0 forced 1, bits 7:6 forced 0, bits 5:2 random
    set_mask = 8'h03; clr_mask = 8'hC0; enable = 1'b1; vec_ready = 1'b1;
    xs = 32'h1234_5678; frc_bad = 0;
    for (int b = 0; b < W; b++) ones[b] = 0;
    for (int k = 0; k < 1000; k++) begin
      xs = xs ^ (xs << 13); xs = xs ^ (xs >> 17); xs = xs ^ (xs << 5);
      rnd_in = xs[W-1:0];
      step();
      if ((vec_data & 8'hC3) != 8'h03) frc_bad++;
      for (int b = 0; b < W; b++) ones[b] += vec_data[b];
    end
    chk("R10 forced bits constant", frc_bad, 0);
    for (int b = 2; b < 6; b++)
      chk("R10 ones ratio in 400..600", (ones[b] >= 400 && ones[b] <= 600), 1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule